// File: doc/BRIEF.md
# Up/down timer with update event

A general-purpose counter for a peripheral subsystem. A prescaler divides the system clock, gated by an external clock-enable input, and the main counter moves one step per prescaler period. The counter runs between zero and a reload value, either in one direction and wrapping, or back and forth. Each wrap or turn-around is an update event. An update event sets a sticky flag, and that flag, masked by an interrupt enable, drives the interrupt line.

Software sees seven registers on a simple single-cycle port:

| Address | Contents |
|---|---|
| 0 | control |
| 1 | event generation |
| 2 | status |
| 3 | interrupt enable |
| 4 | counter (read-only) |
| 5 | prescaler value |
| 6 | reload value |

Unused addresses read as zero. Every write takes effect at the clock edge that samples it. Reads are combinational.

Top module: `updn_timer`

## Requirements
- R1: After reset, the registers read as follows. Control, status, interrupt enable, prescaler value and counter read 0. The reload value reads all ones for the counter width (0xFF or 0xFFFF). The interrupt output is low.
- R2: While the clock-enable input is high, the counter steps once every N cycles. N is PSC+1 in the linear prescaler mode, 2^PSC[2:0] in the 3-bit power-of-two mode, and 2^PSC[3:0] in the 4-bit power-of-two mode. After a software update, the first step comes N enabled cycles later.
- R3: The direction is control bit 4 (0 = up), and the alignment field is control bits 6:5. With bit 4 at 0 and bits 6:5 at 0, the counter counts 0, 1, ..., ARR. The step after ARR loads 0 and is an update event.
- R4: With bit 4 at 1 and bits 6:5 at 0, the counter counts ARR down to 0. The step after 0 loads ARR and is an update event.
- R5: When bits 6:5 are non-zero, the counter runs in centre-aligned mode. At ARR while counting up, the next step loads ARR-1 and sets bit 4. At 0 while counting down, the next step loads 1 and clears bit 4. Each turn is an update event.
- R6: While the current value of bits 6:5 is non-zero, a control write leaves bit 4 unchanged. All other control bits take the written value.
- R7: While control bit 1 is set, wraps and turns still reload the counter, but they set no status flag.
- R8: When control bit 3 is set, an update event clears control bit 0, which is the enable. The counter then stops.
- R9: Writing address 1 with bit 0 set gives a software update event. This event sets the status flag and restarts the prescaler. It also loads the counter with 0 when counting up and with ARR when counting down, except when bit 3 is set, in which case it only clears bit 0. Address 1 always reads as 0.
- R10: Status bit 0 is the update flag. Writing 0 to it clears it, and writing 1 to it has no effect. The interrupt output equals status bit 0 AND interrupt-enable bit 0.
- R11: The counter holds while the clock-enable input is low, and it also holds while control bit 0 is 0. Register writes and reads still work in both cases.
- R12: The counter and reload value are CNT_W bits wide (8 or 16). Upper write bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| clk_en | input | 1 | count clock enable; prescaler advances only while high |
| reg_wr | input | 1 | write strobe for the register port |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 16 | write data |
| reg_rdata | output | 16 | read data for reg_addr (combinational) |
| irq | output | 1 | update interrupt request |

## Verification
The bench builds two instances side by side, and both receive the same register traffic. The first instance uses an 8-bit counter with the linear prescaler. The second uses a 16-bit counter with the 4-bit power-of-two prescaler. The sweep covers all three counting modes, several small reload values, three prescaler settings and several run lengths, both with and without update suppression. For each run the bench derives the counter, the direction and the flag arithmetically for both instances. The 8-bit width brings reload masking and the all-ones reset value into view. Small reload values make every wrap and every turn-around in centre mode land inside short runs.

// File: rtl/updn_timer_pkg.sv
// Package: shared register addresses, control bit positions and prescaler
// mode codes for the up/down timer. Assumes a 16-bit register port.
package updn_timer_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_EVGEN  = 3'd1,
        A_STAT   = 3'd2,
        A_IRQEN  = 3'd3,
        A_COUNT  = 3'd4,
        A_PRESC  = 3'd5,
        A_RELOAD = 3'd6
    } reg_addr_e;

    // control register bit positions (software-visible)
    localparam int B_EN     = 0;
    localparam int B_UDIS   = 1;
    localparam int B_URS    = 2;
    localparam int B_OPM    = 3;
    localparam int B_DIR    = 4;
    localparam int B_CMS_LO = 5;
    localparam int B_CMS_HI = 6;
    localparam int B_ARPE   = 7;

    // prescaler ratio forms
    localparam int PSC_LINEAR = 0;
    localparam int PSC_POW2_3 = 1;
    localparam int PSC_POW2_4 = 2;
endpackage

// File: rtl/updn_timer_presc.sv
// Prescaler: a down-counter that emits one tick every N enabled cycles.
// N comes from the programmed value in the form chosen by PSC_MODE.
// Assumes PSC_W >= 16 for the power-of-two forms.
module updn_timer_presc
    import updn_timer_pkg::*;
#(
    parameter int PSC_MODE = PSC_LINEAR,
    parameter int PSC_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam logic [PSC_W-1:0] ZERO = '0;
    localparam logic [PSC_W-1:0] ONE  = PSC_W'(1);

    logic [PSC_W-1:0] reload;
    logic [PSC_W-1:0] div_q;

    // reload value is ratio minus one, per selected ratio form
    generate
        if (PSC_MODE == PSC_POW2_3) begin : g_pow2_3
            assign reload = PSC_W'((32'd1 << psc[2:0]) - 32'd1);
        end else if (PSC_MODE == PSC_POW2_4) begin : g_pow2_4
            assign reload = PSC_W'((32'd1 << psc[3:0]) - 32'd1);
        end else begin : g_linear
            assign reload = psc;
        end
    endgenerate

    assign tick = clk_en && (div_q == ZERO) && !restart;

    // divide counter: restart on software update, reload on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= ZERO;
        else if (restart)      div_q <= reload;
        else if (clk_en) begin
            if (div_q == ZERO) div_q <= reload;
            else               div_q <= div_q - ONE;
        end
    end
endmodule

// File: rtl/updn_timer_count.sv
// Main counter: steps up or down, wraps in edge-aligned mode or turns in
// centre-aligned mode, and flags the boundary step as a wrap. A software
// update load takes priority over a step. Assumes step and ug_load are
// never high together.
module updn_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ug_load,
    input  logic             dir_down,
    input  logic             centre,
    input  logic [CNT_W-1:0] arr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_top, at_bot, arr_zero;

    // next-count selection and boundary detection
    always_comb begin
        at_top   = (cnt_q >= arr);
        at_bot   = (cnt_q == ZERO);
        arr_zero = (arr == ZERO);
        wrap     = step && (dir_down ? at_bot : at_top);
        cnt_d    = cnt_q;
        if (ug_load) begin
            cnt_d = dir_down ? arr : ZERO;
        end else if (step) begin
            if (!dir_down) begin
                if (at_top) cnt_d = centre ? (arr_zero ? ZERO : arr - ONE) : ZERO;
                else        cnt_d = cnt_q + ONE;
            end else begin
                if (at_bot) cnt_d = centre ? (arr_zero ? ZERO : ONE) : arr;
                else        cnt_d = cnt_q - ONE;
            end
        end
    end

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/updn_timer_regs.sv
// Register file: control, status flag, interrupt enable, prescaler and
// reload storage, plus the read multiplexer. Hardware requests (enable
// clear, direction flip, flag set) merge with software writes here.
// Assumes single-cycle writes.
module updn_timer_regs
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              opm_stop,
    input  logic              dir_flip,
    input  logic              uif_set,
    output logic [CTRL_W-1:0] cr1,
    output logic              ier,
    output logic [PSC_W-1:0]  psc,
    output logic [CNT_W-1:0]  arr,
    output logic              uif
);
    logic [CTRL_W-1:0] cr1_q, cr1_hw, cr1_d;
    logic              ier_q, uif_q;
    logic [PSC_W-1:0]  psc_q;
    logic [CNT_W-1:0]  arr_q;
    logic              wr_ctrl, wr_stat, wr_irqen, wr_presc, wr_reload;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == A_STAT);
    assign wr_irqen  = reg_wr && (reg_addr == A_IRQEN);
    assign wr_presc  = reg_wr && (reg_addr == A_PRESC);
    assign wr_reload = reg_wr && (reg_addr == A_RELOAD);

    // control next value: hardware updates, then a software write that
    // keeps the hardware-owned direction while centre mode is active
    always_comb begin
        cr1_hw = cr1_q;
        if (opm_stop) cr1_hw[B_EN]  = 1'b0;
        if (dir_flip) cr1_hw[B_DIR] = ~cr1_q[B_DIR];
        cr1_d = cr1_hw;
        if (wr_ctrl) begin
            cr1_d = reg_wdata[CTRL_W-1:0];
            if (cr1_q[B_CMS_HI:B_CMS_LO] != 2'b00) cr1_d[B_DIR] = cr1_hw[B_DIR];
        end
    end

    // storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr1_q <= '0;
            ier_q <= 1'b0;
            psc_q <= '0;
            arr_q <= '1;
            uif_q <= 1'b0;
        end else begin
            cr1_q <= cr1_d;
            if (wr_irqen)                   ier_q <= reg_wdata[0];
            if (wr_presc)                   psc_q <= reg_wdata[PSC_W-1:0];
            if (wr_reload)                  arr_q <= reg_wdata[CNT_W-1:0];
            if (uif_set)                    uif_q <= 1'b1;
            else if (wr_stat && !reg_wdata[0]) uif_q <= 1'b0;
        end
    end

    // read multiplexer
    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = BUS_W'(cr1_q);
            A_STAT:   reg_rdata = BUS_W'(uif_q);
            A_IRQEN:  reg_rdata = BUS_W'(ier_q);
            A_COUNT:  reg_rdata = BUS_W'(cnt);
            A_PRESC:  reg_rdata = BUS_W'(psc_q);
            A_RELOAD: reg_rdata = BUS_W'(arr_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign cr1 = cr1_q;
    assign ier = ier_q;
    assign psc = psc_q;
    assign arr = arr_q;
    assign uif = uif_q;
endmodule

// File: rtl/updn_timer.sv
// Top: up/down timer with prescaler, reload value, update events and an
// update interrupt. Joins prescaler, counter and register file and derives
// the update event. Assumes CNT_W is 8 or 16.
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PSC_MODE = PSC_LINEAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int PSC_W = BUS_W;

    logic [CTRL_W-1:0] cr1_q;
    logic              ier_q, uif_q;
    logic [PSC_W-1:0]  psc_q;
    logic [CNT_W-1:0]  arr_q, cnt_q;
    logic              tick, step, wrap, ug, ug_load, upd_evt, opm_stop, dir_flip, centre;

    // event decode
    assign ug       = reg_wr && (reg_addr == A_EVGEN) && reg_wdata[0];
    assign centre   = (cr1_q[B_CMS_HI:B_CMS_LO] != 2'b00);
    assign step     = tick && cr1_q[B_EN];
    assign upd_evt  = ug || (wrap && !cr1_q[B_UDIS]);
    assign opm_stop = upd_evt && cr1_q[B_OPM];
    assign ug_load  = ug && !cr1_q[B_OPM];
    assign dir_flip = wrap && centre;
    assign irq      = uif_q && ier_q;

    updn_timer_presc #(.PSC_MODE(PSC_MODE), .PSC_W(PSC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .restart(ug),
        .psc(psc_q), .tick(tick)
    );

    updn_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .step(step), .ug_load(ug_load),
        .dir_down(cr1_q[B_DIR]), .centre(centre), .arr(arr_q),
        .cnt(cnt_q), .wrap(wrap)
    );

    updn_timer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt(cnt_q),
        .opm_stop(opm_stop), .dir_flip(dir_flip), .uif_set(upd_evt),
        .cr1(cr1_q), .ier(ier_q), .psc(psc_q), .arr(arr_q), .uif(uif_q)
    );
endmodule

// File: rtl/updn_timer_chk.sv
// Checker: temporal properties of the up/down timer, bound to the top.
// Assumes synchronous active-low reset.
module updn_timer_chk
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BUS_W-1:0]  reg_rdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  arr_q,
    input logic [CTRL_W-1:0] cr1_q,
    input logic              uif_q,
    input logic              step,
    input logic              wrap,
    input logic              ug,
    input logic              upd_evt
);
    logic centre_c;
    assign centre_c = (cr1_q[B_CMS_HI:B_CMS_LO] != 2'b00);

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !ug) |=> $stable(cnt_q)) else $error("gated count moved"); // R11
    AST_FLAG_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> uif_q) else $error("update left flag clear"); // R3
    AST_UDIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && cr1_q[B_UDIS] && !ug && !(reg_wr && reg_addr == A_STAT)) |=> $stable(uif_q))
        else $error("suppressed wrap touched flag"); // R7
    AST_OPM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && cr1_q[B_OPM] && !(reg_wr && reg_addr == A_CTRL)) |=> !cr1_q[B_EN])
        else $error("one-pulse did not stop"); // R8
    AST_DIR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (centre_c && !wrap) |=> $stable(cr1_q[B_DIR])) else $error("direction changed"); // R6
    AST_EVGEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_EVGEN) |-> (reg_rdata == '0)) else $error("event reg nonzero"); // R9
    AST_EDGE_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cr1_q[B_DIR] && !centre_c && cnt_q == arr_q) |=> (cnt_q == '0))
        else $error("edge up wrap wrong"); // R3
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .cnt_q(cnt_q), .arr_q(arr_q),
    .cr1_q(cr1_q), .uif_q(uif_q), .step(step), .wrap(wrap), .ug(ug),
    .upd_evt(upd_evt)
);

// File: tb/updn_timer_test.sv
`timescale 1ns/1ps
module updn_timer_test;
    import updn_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;
    int          nchk = 0;
    int          nerr = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    updn_timer #(.CNT_W(8), .PSC_MODE(PSC_LINEAR)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq(irq_a));

    updn_timer #(.CNT_W(16), .PSC_MODE(PSC_POW2_4)) uut_p2 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq(irq_b));

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] va, output logic [15:0] vb);
        reg_addr = a;
        #1;
        va = rdata_a; vb = rdata_b;
    endtask

    task automatic run_edges(input int k);
        @(negedge clk) clk_en = 1'b1;
        repeat (k) @(posedge clk);
        @(negedge clk) clk_en = 1'b0;
    endtask

    function automatic int exp_cnt(input int mode, input int a, input int s);
        int p;
        if (mode == 0) return s % (a + 1);
        if (mode == 1) return a - (s % (a + 1));
        p = s % (2 * a);
        return (p <= a) ? p : 2 * a - p;
    endfunction

    function automatic int exp_dir(input int mode, input int a, input int s);
        int p;
        if (mode == 0) return 0;
        if (mode == 1) return 1;
        p = s % (2 * a);
        return ((p > a) || (p == 0 && s > 0)) ? 1 : 0;
    endfunction

    function automatic int a_of(input int i);
        case (i) 0: return 1; 1: return 2; 2: return 3; default: return 6; endcase
    endfunction

    function automatic int k_of(input int i);
        case (i) 0: return 4; 1: return 9; default: return 17; endcase
    endfunction

    // one sweep point: configure, software update, clear flag, run k cycles
    task automatic sweep_run(input int mode, input int a, input int p, input int k, input int udis);
        logic [15:0] va, vb;
        int cfg, sa, sb, ctl_a, ctl_b;
        string tg, tf;
        tg = (mode == 0) ? "R3/R2" : (mode == 1) ? "R4/R2" : "R5/R2";
        tf = udis ? "R7" : tg;
        wr(A_CTRL, 16'h0); wr(A_CTRL, 16'h0);
        wr(A_RELOAD, 16'(a)); wr(A_PRESC, 16'(p));
        cfg = 1 | (udis << 1) | ((mode == 1) ? 16 : 0) | ((mode == 2) ? 32 : 0);
        wr(A_CTRL, 16'(cfg));
        wr(A_EVGEN, 16'h1);
        wr(A_STAT, 16'h0);
        run_edges(k);
        sa = k / (p + 1);      // linear ratio
        sb = k / (1 << p);     // power-of-two ratio
        rd(A_COUNT, va, vb);
        chk(tg, "count uut", va, 16'(exp_cnt(mode, a, sa)));
        chk(tg, "count uut_p2", vb, 16'(exp_cnt(mode, a, sb)));
        rd(A_STAT, va, vb);
        chk(tf, "flag uut", va, 16'((sa >= a + 1 && udis == 0) ? 1 : 0));
        chk(tf, "flag uut_p2", vb, 16'((sb >= a + 1 && udis == 0) ? 1 : 0));
        ctl_a = (cfg & ~16) | (exp_dir(mode, a, sa) << 4);
        ctl_b = (cfg & ~16) | (exp_dir(mode, a, sb) << 4);
        rd(A_CTRL, va, vb);
        chk(tg, "ctrl uut", va, 16'(ctl_a));
        chk(tg, "ctrl uut_p2", vb, 16'(ctl_b));
    endtask

    initial begin
        logic [15:0] va, vb;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, va, vb);   chk("R1", "ctrl", va, 16'h0);   chk("R1", "ctrl p2", vb, 16'h0);
        rd(A_COUNT, va, vb);  chk("R1", "count", va, 16'h0);  chk("R1", "count p2", vb, 16'h0);
        rd(A_RELOAD, va, vb); chk("R1", "reload", va, 16'h00FF); chk("R1", "reload p2", vb, 16'hFFFF);
        rd(A_PRESC, va, vb);  chk("R1", "presc", va, 16'h0);
        rd(A_STAT, va, vb);   chk("R1", "flag", va, 16'h0);
        rd(A_IRQEN, va, vb);  chk("R1", "irqen", va, 16'h0);
        chk("R1", "irq", 16'(irq_a), 16'h0);

        // R12 width masking
        wr(A_RELOAD, 16'h01FF);
        rd(A_RELOAD, va, vb); chk("R12", "reload mask", va, 16'h00FF); chk("R12", "reload p2", vb, 16'h01FF);

        // R11 clock-enable gating and disabled counter
        wr(A_RELOAD, 16'h0010); wr(A_PRESC, 16'h0);
        wr(A_CTRL, 16'h0001); wr(A_EVGEN, 16'h1); wr(A_STAT, 16'h0);
        repeat (20) @(negedge clk);
        rd(A_COUNT, va, vb); chk("R11", "gated count", va, 16'h0); chk("R11", "gated count p2", vb, 16'h0);
        wr(A_IRQEN, 16'h1);
        rd(A_IRQEN, va, vb); chk("R11", "write while gated", va, 16'h1);
        wr(A_CTRL, 16'h0000);
        run_edges(10);
        rd(A_COUNT, va, vb); chk("R11", "disabled count", va, 16'h0);

        // R9 software update loads and event register reads zero
        wr(A_CTRL, 16'h0001);
        run_edges(5);
        rd(A_COUNT, va, vb); chk("R9", "pre count", va, 16'h5);
        wr(A_EVGEN, 16'h1);
        rd(A_EVGEN, va, vb); chk("R9", "evgen read", va, 16'h0);
        rd(A_COUNT, va, vb); chk("R9", "up load", va, 16'h0);
        wr(A_CTRL, 16'h0011); wr(A_EVGEN, 16'h1);
        rd(A_COUNT, va, vb); chk("R9", "down load", va, 16'h10); chk("R9", "down load p2", vb, 16'h10);

        // R10 flag clearing and interrupt masking
        wr(A_STAT, 16'h0);
        @(negedge clk); chk("R10", "irq low", 16'(irq_a), 16'h0);
        wr(A_EVGEN, 16'h1);
        @(negedge clk); chk("R10", "irq high", 16'(irq_a), 16'h1);
        wr(A_STAT, 16'h1);
        rd(A_STAT, va, vb); chk("R10", "write one keeps", va, 16'h1);
        wr(A_STAT, 16'h0);
        rd(A_STAT, va, vb); chk("R10", "write zero clears", va, 16'h0);
        chk("R10", "irq after clear", 16'(irq_a), 16'h0);
        wr(A_IRQEN, 16'h0); wr(A_EVGEN, 16'h1);
        @(negedge clk); chk("R10", "irq masked", 16'(irq_b), 16'h0);

        // R6 direction locked in centre mode
        wr(A_CTRL, 16'h0); wr(A_CTRL, 16'h0);
        wr(A_RELOAD, 16'h3); wr(A_CTRL, 16'h0021); wr(A_EVGEN, 16'h1);
        run_edges(4);
        rd(A_CTRL, va, vb); chk("R6", "centre down", va, 16'h0031);
        wr(A_CTRL, 16'h0021);
        rd(A_CTRL, va, vb); chk("R6", "dir write ignored", va, 16'h0031);
        wr(A_CTRL, 16'h0020);
        rd(A_CTRL, va, vb); chk("R6", "other bits taken", va, 16'h0030);
        wr(A_CTRL, 16'h0); wr(A_CTRL, 16'h0);
        wr(A_CTRL, 16'h0021); wr(A_CTRL, 16'h0031);
        rd(A_CTRL, va, vb); chk("R6", "dir up kept", va, 16'h0021);

        // R8 one-pulse stop on counter wrap
        wr(A_CTRL, 16'h0); wr(A_CTRL, 16'h0);
        wr(A_CTRL, 16'h0001); wr(A_EVGEN, 16'h1); wr(A_STAT, 16'h0);
        wr(A_CTRL, 16'h0009);
        run_edges(10);
        rd(A_COUNT, va, vb); chk("R8", "stopped count", va, 16'h0); chk("R8", "stopped count p2", vb, 16'h0);
        rd(A_CTRL, va, vb);  chk("R8", "enable cleared", va, 16'h0008);
        rd(A_STAT, va, vb);  chk("R8", "flag", va, 16'h1);

        // R8 and R9: software update in one-pulse mode only stops
        wr(A_CTRL, 16'h0001); wr(A_EVGEN, 16'h1); wr(A_STAT, 16'h0);
        run_edges(2);
        wr(A_CTRL, 16'h0009); wr(A_EVGEN, 16'h1);
        rd(A_CTRL, va, vb);  chk("R8", "ug stop", va, 16'h0008);
        rd(A_COUNT, va, vb); chk("R9", "ug no load", va, 16'h2);
        rd(A_STAT, va, vb);  chk("R9", "ug flag", va, 16'h1);

        // R2 R3 R4 R5 R7 sweep over mode, reload, prescaler, run length
        for (int ud = 0; ud < 2; ud++)
            for (int mode = 0; mode < 3; mode++)
                for (int ai = 0; ai < 4; ai++)
                    for (int p = 0; p < 3; p++)
                        for (int ki = 0; ki < 3; ki++)
                            sweep_run(mode, a_of(ai), p, k_of(ki), ud);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule